// File: doc/BRIEF.md
# Shift-Register Sequence Self-Test Checker

This block decides whether a captured buffer of random-generator output words shows the signature of a known pseudo-random sequence. After a start pulse it takes a seed and a feedback polynomial. It then reads the buffer repeatedly through a synchronous read port. In every pass it counts how many buffer words equal the current expected value, and it keeps a running total of those counts across passes. Between passes the expected value advances by one Galois shift-register step.

The test passes as soon as the running total reaches a match goal at the end of a pass. It fails when a fixed number of passes has run without reaching the goal. Word 0 of the buffer is never read, because the first captured word is treated as unreliable. Another agent fills the buffer, and this block only reads it. Each pass takes N clock cycles for a buffer of N words: N-1 reads followed by one evaluation cycle.

Top module: `lfsr_selftest_chk`

## Requirements
- R1: After reset, `done`, `pass`, `busy` and `rd_en` are all 0.
- R2: A `start` pulse sampled while idle raises `busy` from the next cycle. Each pass then asserts `rd_en` for N-1 consecutive cycles with `rd_addr` going 1, 2, … N-1, followed by one cycle with `rd_en` low. Address 0 is never read.
- R3: Read data returns one cycle after its address. Every returned word equal to the current expected value adds one to the match total, so repeated equal words each count.
- R4: If the total is at least GOAL at the end of a pass, the checker stops with `pass`=1. `pass` is 0 at all times while `busy` is high.
- R5: The first pass compares against the seed. Each later pass compares against the previous value shifted left by one, XORed with `poly` when the bit shifted out of position W-1 was 1.
- R6: If LIMIT passes finish without reaching GOAL, the checker stops with `pass`=0. A run of k passes ends with `done` high exactly k·N cycles after the start edge.
- R7: `done` is high for exactly one cycle, in the first idle cycle. `pass` holds its value until the next accepted start.
- R8: A `start` pulse sampled while `busy` is high has no effect on the run, its reads, its timing or its result.
- R9: The match total carries over between passes, so matches spread across several passes add up toward GOAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test when idle |
| seed | input | W | Expected value for the first pass |
| poly | input | W | Feedback polynomial for the Galois step |
| rd_en | output | 1 | Buffer read request |
| rd_addr | output | $clog2(N) | Buffer word address |
| rd_data | input | W | Buffer word, valid one cycle after the request |
| done | output | 1 | One-cycle end-of-test pulse |
| pass | output | 1 | Test verdict, held until the next start |
| busy | output | 1 | Test in progress |

## Verification
Most internal errors show up as a wrong end time, because the cycle of `done` encodes the number of passes used. A miscounted total, a wrong polynomial step or a stale expected value moves that cycle by a multiple of N, or flips `pass`. A faulty address counter or a read of word 0 shows up at once in the per-cycle `rd_en`/`rd_addr` pattern. A start that is not ignored while busy shows up within one pass, as a restarted address sequence or a changed verdict.

// File: rtl/lfsr_st_pkg.sv
package lfsr_st_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_EVAL = 2'd2
  } st_state_t;
endpackage

// File: rtl/lst_galois_step.sv
module lst_galois_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] poly,
  output logic [W-1:0] nxt
);
  logic [W-1:0] shifted;
  always_comb begin
    shifted = {cur[W-2:0], 1'b0};
    nxt     = cur[W-1] ? (shifted ^ poly) : shifted;
  end
endmodule

// File: rtl/lst_addr_gen.sv
module lst_addr_gen #(
  parameter int N  = 8,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  output logic [AW-1:0] addr,
  output logic          last
);
  localparam logic [AW-1:0] FIRST = AW'(1);
  localparam logic [AW-1:0] FINAL = AW'(N - 1);

  always_ff @(posedge clk) begin
    if (rst)       addr <= FIRST;
    else if (load) addr <= FIRST;
    else if (adv)  addr <= addr + AW'(1);
  end

  assign last = (addr == FINAL);
endmodule

// File: rtl/lst_word_match.sv
module lst_word_match #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en,
  input  logic [W-1:0] rd_data,
  input  logic [W-1:0] expected,
  output logic         hit
);
  logic vld_q;
  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= rd_en;
  end
  assign hit = vld_q && (rd_data == expected);
endmodule

// File: rtl/lfsr_selftest_chk.sv
module lfsr_selftest_chk
  import lfsr_st_pkg::*;
#(
  parameter int W     = 64,
  parameter int N     = 8,
  parameter int GOAL  = 7,
  parameter int LIMIT = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [W-1:0]         seed,
  input  logic [W-1:0]         poly,
  output logic                 rd_en,
  output logic [$clog2(N)-1:0] rd_addr,
  input  logic [W-1:0]         rd_data,
  output logic                 done,
  output logic                 pass,
  output logic                 busy
);
  localparam int AW = $clog2(N);
  localparam int TW = $clog2(GOAL + N + 1);
  localparam int IW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] GOAL_T = TW'(GOAL);
  localparam logic [IW-1:0] LAST_I = IW'(LIMIT - 1);

  st_state_t     state_q;
  logic [W-1:0]  exp_q, exp_nx;
  logic [TW-1:0] total_q, total_nx;
  logic [IW-1:0] iter_q;
  logic          hit, last, addr_load;

  lst_galois_step #(.W(W)) u_step (
    .cur(exp_q), .poly(poly), .nxt(exp_nx)
  );

  lst_addr_gen #(.N(N), .AW(AW)) u_addr (
    .clk(clk), .rst(rst), .load(addr_load), .adv(rd_en),
    .addr(rd_addr), .last(last)
  );

  lst_word_match #(.W(W)) u_match (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_data(rd_data),
    .expected(exp_q), .hit(hit)
  );

  assign rd_en    = (state_q == ST_SCAN);
  assign busy     = (state_q != ST_IDLE);
  assign total_nx = total_q + TW'(hit);
  assign addr_load = ((state_q == ST_IDLE) && start) ||
                     ((state_q == ST_EVAL) && (total_nx < GOAL_T) && (iter_q != LAST_I));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      exp_q   <= '0;
      total_q <= '0;
      iter_q  <= '0;
      done    <= 1'b0;
      pass    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            exp_q   <= seed;
            total_q <= '0;
            iter_q  <= '0;
            pass    <= 1'b0;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          total_q <= total_nx;
          if (last) state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          total_q <= total_nx;
          if (total_nx >= GOAL_T) begin
            done    <= 1'b1;
            pass    <= 1'b1;
            state_q <= ST_IDLE;
          end else if (iter_q == LAST_I) begin
            done    <= 1'b1;
            pass    <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            iter_q  <= iter_q + IW'(1);
            exp_q   <= exp_nx;
            state_q <= ST_SCAN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  rd_addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_addr != '0) && (int'(rd_addr) < N));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R4
  pass_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !pass);

  // R6
  iter_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(iter_q) < LIMIT);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && start && !last) |=> rd_en && (rd_addr == $past(rd_addr) + AW'(1)) && $stable(exp_q));
endmodule

// File: tb/tb_lfsr_selftest_chk.sv
module tb_lfsr_selftest_chk;
  localparam int W = 64, N = 8, GOAL = 7, LIMIT = 16;
  localparam int AW = $clog2(N);
  localparam logic [W-1:0] POLY = 64'h2E9A_B5C7_4A2B_1013;

  logic          clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [W-1:0]  seed = '0, poly = POLY, rd_data;
  logic          rd_en, done, pass, busy;
  logic [AW-1:0] rd_addr;
  logic [W-1:0]  mem [N];
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  lfsr_selftest_chk #(.W(W), .N(N), .GOAL(GOAL), .LIMIT(LIMIT)) dut (
    .clk(clk), .rst(rst), .start(start), .seed(seed), .poly(poly),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .pass(pass), .busy(busy)
  );

  function automatic logic [W-1:0] step(logic [W-1:0] v, logic [W-1:0] p);
    logic [W-1:0] s = v << 1;
    return v[W-1] ? (s ^ p) : s;
  endfunction

  function automatic logic [W-1:0] stepn(logic [W-1:0] v, logic [W-1:0] p, int n);
    for (int i = 0; i < n; i++) v = step(v, p);
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: passes used and verdict
  task automatic model(logic [W-1:0] s, logic [W-1:0] p, output int k, output bit ep);
    int total = 0;
    logic [W-1:0] v = s;
    for (int it = 0; it < LIMIT; it++) begin
      for (int w = 1; w < N; w++) if (mem[w] == v) total++;
      if (total >= GOAL) begin k = it + 1; ep = 1'b1; return; end
      v = step(v, p);
    end
    k = LIMIT; ep = 1'b0;
  endtask

  task automatic run_case(string req, logic [W-1:0] s, int ig_at, logic [W-1:0] ig_seed);
    int k; bit ep; int K;
    model(s, POLY, k, ep);
    K = k * N;
    seed = s;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int j = 0; j <= K + 3; j++) begin
      if (j > 0) @(negedge clk);
      chk(busy == (j < K), "R2 busy", W'(busy), W'(j < K));
      chk(done == (j == K), {req, " R6 R7 done timing"}, W'(done), W'(j == K));
      chk(pass == ((j >= K) ? ep : 1'b0), {req, " R4 R7 pass"}, W'(pass), W'((j >= K) ? ep : 1'b0));
      chk(rd_en == ((j < K) && (j % N != N - 1)), "R2 rd_en", W'(rd_en), W'((j < K) && (j % N != N - 1)));
      if ((j < K) && (j % N != N - 1))
        chk(int'(rd_addr) == (j % N) + 1, "R2 rd_addr", W'(rd_addr), W'((j % N) + 1));
      if (j == ig_at) begin start = 1'b1; seed = ig_seed; end
      else begin start = 1'b0; seed = s; end
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] s1 = 64'h1234_5678_9ABC_DEF0;
    logic [W-1:0] s2 = 64'h8000_0000_0000_0001;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({done, pass, busy, rd_en} == 4'b0, "R1 reset", W'({done, pass, busy, rd_en}), '0);
    rst = 1'b0;
    @(negedge clk);
    chk({done, pass, busy, rd_en} == 4'b0, "R1 idle after reset", W'({done, pass, busy, rd_en}), '0);

    // R3 R4: all scanned words equal the seed -> pass in one pass
    mem[0] = '0;
    for (int w = 1; w < N; w++) mem[w] = s1;
    run_case("R3 R4 single pass", s1, -1, '0);

    // R2: only word 0 holds the seed -> skipped, fail after LIMIT passes
    mem[0] = s1;
    for (int w = 1; w < N; w++) mem[w] = 64'hDEAD_0000_0000_0000 + W'(w);
    run_case("R2 word0 skipped", s1, -1, '0);

    // R5: one stepped value per word, msb set in seed exercises XOR
    mem[0] = '0;
    for (int w = 1; w < N; w++) mem[w] = stepn(s2, POLY, w - 1);
    chk(mem[2] == ((s2 << 1) ^ POLY), "R5 step xor", mem[2], (s2 << 1) ^ POLY);
    run_case("R5 sequence", s2, -1, '0);

    // R9 R3: 4 matches in pass 1, 3 in pass 3
    for (int w = 1; w < 5; w++) mem[w] = s1;
    for (int w = 5; w < N; w++) mem[w] = stepn(s1, POLY, 2);
    run_case("R9 accumulate", s1, -1, '0);

    // R6 boundary: GOAL-1 matches only
    for (int w = 1; w < N - 1; w++) mem[w] = s2;
    mem[N-1] = 64'h0BAD_F00D_0000_0001;
    run_case("R6 goal minus one", s2, -1, '0);

    // R8: start while busy with a seed that would pass is ignored
    for (int w = 1; w < N; w++) mem[w] = s1;
    run_case("R8 start ignored", ~s1, 5, s1);
    run_case("R8 start ignored late", ~s1, 3 * N + 2, s1);

    // R7: pass held across idle cycles, then cleared by a new start
    for (int w = 1; w < N; w++) mem[w] = s2;
    run_case("R7 hold", s2, -1, '0);
    repeat (5) @(negedge clk);
    chk(pass == 1'b1, "R7 pass held", W'(pass), W'(1));
    chk(done == 1'b0, "R7 done low", W'(done), W'(0));
    mem[1] = '0;
    run_case("R7 cleared by start", ~s2, -1, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule